// File: doc/BRIEF.md
# Serial Control Register Port

This block is a small three-wire serial slave that sets the operating controls of an audio rate-conversion datapath. A host drives a chip-enable line, a shift clock and a data line. With the enable low it shifts in an address byte. With the enable high it shifts in a data byte. When the enable drops, the data byte is written into an eight-bit control register, but only if the address named this device and this register and exactly eight data bits arrived.

The register sets five controls: a master clock ratio select, a two-bit input rate code, a mute request and an oscillator stop request. A mode input picks where the controls come from. When it is low they come from the serial register. When it is high they come from dedicated input pins. Every accepted data byte, including the three bits that drive no control, is also presented on an eight-bit parallel output, whatever the mode.

All three serial lines are brought into the system clock domain by synchronisers, and their edges are detected in that domain. The serial clock must therefore be much slower than the system clock.

Top module: `serial_ctrl_port`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register and `par_out` load 0xE8. The controls then read clock select 0, rate code 00, mute 1 and stop 0.
- R2: Serial bits are taken on the rising edge of `ser_clk`, least significant bit first. Address bits are taken while `ser_en` is low and data bits while it is high.
- R3: A frame is accepted only if the last eight address bits before `ser_en` rose match. The first four bits shifted in (bits 3:0) must equal `DEV_ID`, and the next four (bits 7:4) must equal `REG_ID`. Any other address, or fewer than eight address bits, leaves the register and `par_out` unchanged.
- R4: A frame is accepted only if exactly eight data bits were received. A frame with seven or nine data bits leaves the register and `par_out` unchanged.
- R5: An accepted byte is written when `ser_en` falls. Counting from the first rising clock edge after the fall, `par_out` and the register-driven controls still hold the old value after the third edge and show the new value after the fourth.
- R6: With `sel_pins` low, the controls follow the register as follows: bit 0 gives `ctl_clksel` (1 selects 512fs, 0 selects 384fs), bit 1 gives `ctl_rate[0]`, bit 2 gives `ctl_rate[1]`, bit 3 gives `ctl_mute` and bit 4 gives `ctl_stop`. In this mode the control pins have no effect.
- R7: With `sel_pins` high, each control output equals the matching control pin as it was at the previous rising clock edge.
- R8: `par_out` shows every accepted byte, bits 7:5 included, for either value of `sel_pins`. A byte accepted while `sel_pins` is high shows on the controls once `sel_pins` goes low.
- R9: The rate code `{ctl_rate[1], ctl_rate[0]}` reads 00 for 44.1 kHz, 01 for 48 kHz and 11 for 32 kHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_pins | input | 1 | 1: controls come from the pins; 0: controls come from the register |
| ser_en | input | 1 | Serial enable: low for the address phase, high for the data phase |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial address and data line |
| pin_clksel | input | 1 | Clock ratio select pin |
| pin_rate | input | 2 | Input rate code pins |
| pin_mute | input | 1 | Mute request pin |
| pin_stop | input | 1 | Oscillator stop pin |
| ctl_clksel | output | 1 | Clock ratio select control |
| ctl_rate | output | 2 | Input rate code control |
| ctl_mute | output | 1 | Mute control |
| ctl_stop | output | 1 | Oscillator stop control |
| par_out | output | 8 | Last accepted data byte |

## Verification
A pin change driven between clock edges shows on the controls after the next rising edge. A falling `ser_enable` reaches the register after three rising edges, two for synchronisation and one for the write, and reaches the outputs after the fourth. The bench's reference model schedules each expected update with that exact count of edges. It compares every output half a period after each edge. After each accepted frame it also checks explicitly that the old value is still present after the third edge and the new one after the fourth. Each serial level is held for three system clocks, so every sample falls well inside a stable window.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int CFG_W = 8;
  localparam logic [CFG_W-1:0] CFG_RESET = 8'hE8;

  typedef struct packed {
    logic       clksel;
    logic [1:0] rate;
    logic       mute;
    logic       stop;
  } ctl_t;

  function automatic ctl_t cfg_to_ctl(input logic [CFG_W-1:0] c);
    ctl_t r;
    r.clksel = c[0];
    r.rate   = {c[2], c[1]};
    r.mute   = c[3];
    r.stop   = c[4];
    return r;
  endfunction
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= '0;
      else     stg[g] <= stg[g-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scp_rx.sv
module scp_rx #(
  parameter int          NIB_W  = 4,
  parameter int          DATA_W = 8,
  parameter logic [3:0]  DEV_ID = 4'h6,
  parameter logic [3:0]  REG_ID = 4'hB,
  localparam int         ADDR_W = 2 * NIB_W,
  localparam int         AC_W   = $clog2(ADDR_W + 1),
  localparam int         CNT_W  = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_s,
  input  logic              sclk_s,
  input  logic              dat_s,
  output logic [DATA_W-1:0] cfg_q,
  output logic              commit,
  output logic [CNT_W-1:0]  dat_cnt
);
  localparam logic [ADDR_W-1:0] MATCH = {REG_ID[NIB_W-1:0], DEV_ID[NIB_W-1:0]};

  logic              en_d, sclk_d, match_q;
  logic [ADDR_W-1:0] addr_sr;
  logic [AC_W-1:0]   addr_cnt;
  logic [DATA_W-1:0] data_sr;
  logic              clk_rise, en_rise, en_fall;

  assign clk_rise = sclk_s & ~sclk_d;
  assign en_rise  = en_s & ~en_d;
  assign en_fall  = ~en_s & en_d;
  assign commit   = en_fall & match_q & (dat_cnt == CNT_W'(DATA_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d     <= 1'b0;
      sclk_d   <= 1'b0;
      match_q  <= 1'b0;
      addr_sr  <= '0;
      addr_cnt <= '0;
      data_sr  <= '0;
      dat_cnt  <= '0;
      cfg_q    <= scp_pkg::CFG_RESET;
    end else begin
      en_d   <= en_s;
      sclk_d <= sclk_s;
      // address phase
      if (en_fall) begin
        addr_cnt <= '0;
      end else if (clk_rise && !en_s) begin
        addr_sr <= {dat_s, addr_sr[ADDR_W-1:1]};
        if (addr_cnt != AC_W'(ADDR_W)) addr_cnt <= addr_cnt + 1'b1;
      end
      // data phase
      if (en_rise) begin
        match_q <= (addr_cnt == AC_W'(ADDR_W)) && (addr_sr == MATCH);
        dat_cnt <= '0;
      end else if (clk_rise && en_s) begin
        data_sr <= {dat_s, data_sr[DATA_W-1:1]};
        if (dat_cnt != CNT_W'(DATA_W + 1)) dat_cnt <= dat_cnt + 1'b1;
      end
      if (commit) cfg_q <= data_sr;
    end
  end
endmodule

// File: rtl/scp_outmux.sv
module scp_outmux #(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel_pins,
  input  scp_pkg::ctl_t        pin_ctl,
  input  logic [DATA_W-1:0]    cfg_q,
  output scp_pkg::ctl_t        ctl_q,
  output logic [DATA_W-1:0]    par_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= scp_pkg::cfg_to_ctl(scp_pkg::CFG_RESET);
      par_q <= scp_pkg::CFG_RESET;
    end else begin
      ctl_q <= sel_pins ? pin_ctl : scp_pkg::cfg_to_ctl(cfg_q);
      par_q <= cfg_q;
    end
  end
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port #(
  parameter int         NIB_W       = 4,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_ID      = 4'h6,
  parameter logic [3:0] REG_ID      = 4'hB,
  localparam int        CNT_W       = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_pins,
  input  logic              ser_en,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              pin_clksel,
  input  logic [1:0]        pin_rate,
  input  logic              pin_mute,
  input  logic              pin_stop,
  output logic              ctl_clksel,
  output logic [1:0]        ctl_rate,
  output logic              ctl_mute,
  output logic              ctl_stop,
  output logic [DATA_W-1:0] par_out
);
  logic [2:0]        ser_s;
  logic [DATA_W-1:0] cfg_q;
  logic              commit;
  logic [CNT_W-1:0]  dat_cnt;
  scp_pkg::ctl_t     pin_ctl, ctl_q;

  scp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({ser_en, ser_clk, ser_dat}), .q(ser_s)
  );

  scp_rx #(.NIB_W(NIB_W), .DATA_W(DATA_W), .DEV_ID(DEV_ID), .REG_ID(REG_ID)) u_rx (
    .clk(clk), .rst(rst), .en_s(ser_s[2]), .sclk_s(ser_s[1]), .dat_s(ser_s[0]),
    .cfg_q(cfg_q), .commit(commit), .dat_cnt(dat_cnt)
  );

  always_comb begin
    pin_ctl.clksel = pin_clksel;
    pin_ctl.rate   = pin_rate;
    pin_ctl.mute   = pin_mute;
    pin_ctl.stop   = pin_stop;
  end

  scp_outmux #(.DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst(rst), .sel_pins(sel_pins), .pin_ctl(pin_ctl),
    .cfg_q(cfg_q), .ctl_q(ctl_q), .par_q(par_out)
  );

  assign ctl_clksel = ctl_q.clksel;
  assign ctl_rate   = ctl_q.rate;
  assign ctl_mute   = ctl_q.mute;
  assign ctl_stop   = ctl_q.stop;
endmodule

// File: rtl/scp_chk.sv
module scp_chk #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 2)
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_pins,
  input logic              pin_clksel,
  input logic [1:0]        pin_rate,
  input logic              pin_mute,
  input logic              pin_stop,
  input logic              ctl_clksel,
  input logic [1:0]        ctl_rate,
  input logic              ctl_mute,
  input logic              ctl_stop,
  input logic [DATA_W-1:0] par_out,
  input logic [DATA_W-1:0] cfg_q,
  input logic              commit,
  input logic [CNT_W-1:0]  dat_cnt
);
  // R1
  reset_default_chk: assert property (@(posedge clk)
    $fell(rst) |-> (par_out == DATA_W'(scp_pkg::CFG_RESET) && !ctl_clksel &&
                    ctl_rate == 2'b00 && ctl_mute && !ctl_stop));

  // R7
  pins_follow_chk: assert property (@(posedge clk) disable iff (rst)
    sel_pins |=> (ctl_clksel == $past(pin_clksel) && ctl_rate == $past(pin_rate) &&
                  ctl_mute == $past(pin_mute) && ctl_stop == $past(pin_stop)));

  // R5
  write_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_q) |-> ($past(commit) || $past(rst)));

  // R4
  data_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    dat_cnt <= CNT_W'(DATA_W + 1));
endmodule

bind serial_ctrl_port scp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sel_pins(sel_pins), .pin_clksel(pin_clksel),
  .pin_rate(pin_rate), .pin_mute(pin_mute), .pin_stop(pin_stop),
  .ctl_clksel(ctl_clksel), .ctl_rate(ctl_rate), .ctl_mute(ctl_mute),
  .ctl_stop(ctl_stop), .par_out(par_out), .cfg_q(cfg_q), .commit(commit),
  .dat_cnt(dat_cnt)
);

// File: tb/test_serial_ctrl_port.sv
module test_serial_ctrl_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] GOOD_ADDR = 8'hB6;  // REG_ID=B, DEV_ID=6
  localparam logic [7:0] DEF = 8'hE8;

  logic clk = 1'b0, rst = 1'b1;
  logic sel_pins = 1'b0, ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
  logic pin_clksel = 1'b0, pin_mute = 1'b0, pin_stop = 1'b0;
  logic [1:0] pin_rate = 2'b00;
  logic ctl_clksel, ctl_mute, ctl_stop;
  logic [1:0] ctl_rate;
  logic [7:0] par_out;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0, started = 1'b0;
  string tag = "R1";

  // reference model state
  logic [7:0] mreg = DEF, pend_val = 8'h00, exp_par = DEF;
  logic [4:0] exp_ctl = 5'b0;  // {clksel, rate[1:0], mute, stop}
  int pend = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_ctrl_port i_serial_ctrl_port (
    .clk(clk), .rst(rst), .sel_pins(sel_pins), .ser_en(ser_en), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .pin_clksel(pin_clksel), .pin_rate(pin_rate),
    .pin_mute(pin_mute), .pin_stop(pin_stop), .ctl_clksel(ctl_clksel),
    .ctl_rate(ctl_rate), .ctl_mute(ctl_mute), .ctl_stop(ctl_stop), .par_out(par_out)
  );

  function automatic logic [4:0] fields(input logic [7:0] b);
    return {b[0], b[2], b[1], b[3], b[4]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    started = 1'b1;
    cyc++;
    if (rst) begin
      mreg = DEF; pend = 0; exp_par = DEF; exp_ctl = fields(DEF);
    end else begin
      exp_par = mreg;
      exp_ctl = sel_pins ? {pin_clksel, pin_rate, pin_mute, pin_stop} : fields(mreg);
      if (pend > 0) begin
        pend--;
        if (pend == 0) mreg = pend_val;
      end
    end
    if (cyc > 60000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<60000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk({tag, " per-cycle controls"}, {ctl_clksel, ctl_rate, ctl_mute, ctl_stop}, exp_ctl);
      chk({tag, " per-cycle par_out"}, par_out, exp_par);
    end
  end

  task automatic sbit(input logic b);
    ser_dat = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] addr, input int nab,
                            input logic [15:0] dat, input int ndb);
    logic [7:0] old;
    bit valid;
    for (int i = 0; i < nab; i++) sbit(addr[i]);
    repeat (3) @(negedge clk);
    ser_en = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < ndb; i++) sbit(dat[i]);
    repeat (3) @(negedge clk);
    ser_en = 1'b0;
    valid = (nab == 8) && (addr == GOOD_ADDR) && (ndb == 8);
    if (valid) begin
      pend_val = dat[7:0];
      pend = 3;
      old = par_out;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R5 old value after third edge", par_out, old);
      @(posedge clk);
      @(negedge clk);
      chk("R5 new value after fourth edge", par_out, dat[7:0]);
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 par_out reset", par_out, DEF);
    chk("R1 controls reset", {ctl_clksel, ctl_rate, ctl_mute, ctl_stop}, 5'b00010);

    tag = "R2";
    send_frame(GOOD_ADDR, 8, 16'h0015, 8);
    chk("R2 R6 clksel from bit0", ctl_clksel, 1'b1);
    chk("R6 stop from bit4", ctl_stop, 1'b1);
    chk("R6 mute from bit3", ctl_mute, 1'b0);
    chk("R8 par_out byte", par_out, 8'h15);

    tag = "R9";
    send_frame(GOOD_ADDR, 8, 16'h0002, 8);
    chk("R9 48k code", ctl_rate, 2'b01);
    send_frame(GOOD_ADDR, 8, 16'h0006, 8);
    chk("R9 32k code", ctl_rate, 2'b11);
    send_frame(GOOD_ADDR, 8, 16'h0008, 8);
    chk("R9 44.1k code", ctl_rate, 2'b00);

    tag = "R3";
    send_frame(8'hB7, 8, 16'h0033, 8);
    chk("R3 wrong device ignored", par_out, 8'h08);
    send_frame(8'hA6, 8, 16'h0033, 8);
    chk("R3 wrong register ignored", par_out, 8'h08);
    send_frame(GOOD_ADDR, 7, 16'h0033, 8);
    chk("R3 short address ignored", par_out, 8'h08);

    tag = "R4";
    send_frame(GOOD_ADDR, 8, 16'h0055, 7);
    chk("R4 seven data bits ignored", par_out, 8'h08);
    send_frame(GOOD_ADDR, 8, 16'h0155, 9);
    chk("R4 nine data bits ignored", par_out, 8'h08);

    tag = "R8";
    send_frame(GOOD_ADDR, 8, 16'h00E0, 8);
    chk("R8 upper bits on par_out", par_out, 8'hE0);
    chk("R8 upper bits drive no control", {ctl_clksel, ctl_rate, ctl_mute, ctl_stop}, 5'b0);

    tag = "R6";
    pin_clksel = 1'b1; pin_rate = 2'b11; pin_mute = 1'b1; pin_stop = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 pins ignored in register mode", {ctl_clksel, ctl_rate, ctl_mute, ctl_stop}, 5'b0);

    tag = "R7";
    sel_pins = 1'b1;
    @(negedge clk);
    chk("R7 controls follow pins", {ctl_clksel, ctl_rate, ctl_mute, ctl_stop}, 5'b11111);
    pin_rate = 2'b01; pin_stop = 1'b0;
    @(negedge clk);
    chk("R7 pin change next edge", {ctl_rate, ctl_stop}, 3'b010);

    tag = "R8";
    send_frame(GOOD_ADDR, 8, 16'h000A, 8);
    chk("R8 par_out updates in pin mode", par_out, 8'h0A);
    chk("R7 controls still from pins", {ctl_clksel, ctl_rate, ctl_mute, ctl_stop}, 5'b10110);

    tag = "R6";
    sel_pins = 1'b0;
    @(negedge clk);
    chk("R8 R6 stored byte drives controls", {ctl_clksel, ctl_rate, ctl_mute, ctl_stop}, 5'b00110);

    tag = "R1";
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 par_out after second reset", par_out, DEF);
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule